// File: doc/BRIEF.md
# Keypad Matrix Column Scanner

This block scans a key matrix of four columns by eight rows. It drives exactly one column line at a time and reads the row byte that comes back. While every row bit reads zero it steps to the next column on each scan tick. When a nonzero row byte appears, it reports the driven column and the raw row byte with a one-cycle valid pulse. It then stays parked on that column until the key is released.

The release wait is tied to the exact row pattern that was reported. Scanning resumes only after the row byte has moved to a different value and has read as that same new value on two scan ticks in a row. A short glitch therefore does not end the wait. The row inputs are brought into the clock domain through a synchroniser chain before any decision is made. The scan tick sets the pace, so a column is sampled one tick after it was first driven, which gives the matrix lines time to settle.

Top module: `keypad_scanner`

## Requirements
- R1: The column output is always one-hot. After reset it is 4'b0001. Each advance moves it one place up: 0001, 0010, 0100, 1000, then back to 0001.
- R2: The column output changes only on a clock edge at which `scan_tick` is high. With no tick it holds its value for any number of cycles.
- R3: On a tick during scanning, a nonzero synchronised row byte produces a report. `key_col` takes the one-hot column being driven and `key_row` takes the row byte bit for bit, bit i standing for row line i. The codes change only when a report is made.
- R4: On a tick during scanning, a zero synchronised row byte advances the column. The new column is therefore first sampled on the following tick.
- R5: After a report, the column stays where it is while the synchronised row byte equals the reported byte. When the wait ends, the column advances by one place on the same edge.
- R6: `key_valid` is high for exactly one clock cycle per report. It does not rise again during the release wait.
- R7: `key_held` rises in the same cycle as the `key_valid` pulse. It stays high for the whole release wait and is low while scanning.
- R8: The release wait ends only when two consecutive ticks both see the same byte, and that byte differs from the reported one. A differing byte followed by the reported byte, or by a third value, does not end the wait.
- R9: `row_in` passes through a two-register synchroniser before the scan logic sees it. A tick at the first clock edge after a row change still sees the old row value.
- R10: While `rst_n` is low, all outputs take their reset values: column 0001, valid 0, held 0, and both codes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_in | input | 8 | Raw row lines from the matrix, one bit per row |
| scan_tick | input | 1 | One-cycle strobe that paces the scan |
| col_drive | output | 4 | One-hot column drive |
| key_valid | output | 1 | One-cycle pulse when a key is reported |
| key_col | output | 4 | One-hot column of the last report |
| key_row | output | 8 | Raw row byte of the last report |
| key_held | output | 1 | High during the release wait |

## Verification
The checker watches a set of rules on every cycle:
- the column output stays one-hot;
- the column does not move without a tick, and does not move during the release wait;
- `key_valid` is a single-cycle pulse, and `key_held` is high whenever it fires;
- `key_col` matches the driven column at each report, and the codes change only at a report.

Some behaviour only the bench scenarios can show, because it depends on what the row bytes were over several ticks:
- the release needs two matching ticks, so a one-tick bounce does not end the wait;
- a release onto a different nonzero byte resumes scanning, and the key is reported again one full column cycle later;
- a tick right after a row change still sees the old value;
- with a tick on every cycle, the two-cycle synchroniser delay makes a key be reported against the wrong column.

The bench's reference model follows all of these cycle by cycle.

// File: rtl/kp_pkg.sv
package kp_pkg;
    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_WAIT = 1'b1
    } scan_st_e;
endpackage

// File: rtl/kp_row_sync.sv
module kp_row_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_q[g-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/kp_release_det.sv
module kp_release_det #(
    parameter int W = 8
) (
    input  logic [W-1:0] row_s,
    input  logic [W-1:0] reported,
    input  logic         pend_q,
    input  logic [W-1:0] pend_val_q,
    output logic         differs,
    output logic         confirm
);
    // A release is confirmed when the previous tick already saw this same changed value
    always_comb begin
        differs = (row_s != reported);
        confirm = differs && pend_q && (row_s == pend_val_q);
    end
endmodule

// File: rtl/kp_scan_ctrl.sv
module kp_scan_ctrl
    import kp_pkg::*;
#(
    parameter int NUM_COLS = 4,
    parameter int ROW_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [ROW_W-1:0]    row_s,
    output logic [NUM_COLS-1:0] col,
    output logic                valid,
    output logic [NUM_COLS-1:0] kcol,
    output logic [ROW_W-1:0]    krow,
    output logic                held
);
    localparam logic [NUM_COLS-1:0] COL_FIRST = NUM_COLS'(1);

    typedef struct packed {
        scan_st_e            st;
        logic [NUM_COLS-1:0] col;
        logic [NUM_COLS-1:0] kcol;
        logic [ROW_W-1:0]    krow;
        logic                valid;
        logic                pend;
        logic [ROW_W-1:0]    pval;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  differs, confirm;

    kp_release_det #(.W(ROW_W)) u_rel (
        .row_s      (row_s),
        .reported   (ctl_q.krow),
        .pend_q     (ctl_q.pend),
        .pend_val_q (ctl_q.pval),
        .differs    (differs),
        .confirm    (confirm)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        if (tick) begin
            unique case (ctl_q.st)
                ST_SCAN: begin
                    if (row_s != '0) begin
                        ctl_d.st    = ST_WAIT;
                        ctl_d.kcol  = ctl_q.col;
                        ctl_d.krow  = row_s;
                        ctl_d.valid = 1'b1;
                        ctl_d.pend  = 1'b0;
                    end else begin
                        ctl_d.col = {ctl_q.col[NUM_COLS-2:0], ctl_q.col[NUM_COLS-1]};
                    end
                end
                ST_WAIT: begin
                    if (!differs) begin
                        ctl_d.pend = 1'b0;
                    end else if (confirm) begin
                        ctl_d.st   = ST_SCAN;
                        ctl_d.pend = 1'b0;
                        ctl_d.col  = {ctl_q.col[NUM_COLS-2:0], ctl_q.col[NUM_COLS-1]};
                    end else begin
                        ctl_d.pend = 1'b1;
                        ctl_d.pval = row_s;
                    end
                end
                default: ctl_d.st = ST_SCAN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_SCAN;
            ctl_q.col   <= COL_FIRST;
            ctl_q.kcol  <= '0;
            ctl_q.krow  <= '0;
            ctl_q.valid <= 1'b0;
            ctl_q.pend  <= 1'b0;
            ctl_q.pval  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign col   = ctl_q.col;
    assign valid = ctl_q.valid;
    assign kcol  = ctl_q.kcol;
    assign krow  = ctl_q.krow;
    assign held  = (ctl_q.st == ST_WAIT);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
    parameter int NUM_COLS    = 4,
    parameter int ROW_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROW_W-1:0]    row_in,
    input  logic                scan_tick,
    output logic [NUM_COLS-1:0] col_drive,
    output logic                key_valid,
    output logic [NUM_COLS-1:0] key_col,
    output logic [ROW_W-1:0]    key_row,
    output logic                key_held
);
    logic [ROW_W-1:0] row_sync;

    kp_row_sync #(.W(ROW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (row_in),
        .q     (row_sync)
    );

    kp_scan_ctrl #(.NUM_COLS(NUM_COLS), .ROW_W(ROW_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (scan_tick),
        .row_s (row_sync),
        .col   (col_drive),
        .valid (key_valid),
        .kcol  (key_col),
        .krow  (key_row),
        .held  (key_held)
    );
endmodule

// File: rtl/kp_scan_checker.sv
module kp_scan_checker #(
    parameter int NUM_COLS = 4,
    parameter int ROW_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scan_tick,
    input logic [NUM_COLS-1:0] col_drive,
    input logic                key_valid,
    input logic [NUM_COLS-1:0] key_col,
    input logic [ROW_W-1:0]    key_row,
    input logic                key_held
);
    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_drive) == 1); // R1
    AST_COL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(col_drive)); // R2
    AST_REPORT_COL: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> key_col == col_drive); // R3
    AST_CODES_ONLY_AT_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (key_row != $past(key_row) || key_col != $past(key_col)) |-> key_valid); // R3
    AST_WAIT_COL_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        key_held |=> (!key_held || $stable(col_drive))); // R5
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid); // R6
    AST_VALID_WITH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> key_held); // R7
    AST_HELD_RISE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_held) |-> key_valid); // R7
endmodule

bind keypad_scanner kp_scan_checker #(.NUM_COLS(NUM_COLS), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .col_drive (col_drive),
    .key_valid (key_valid),
    .key_col   (key_col),
    .key_row   (key_row),
    .key_held  (key_held)
);

// File: tb/keypad_scanner_test.sv
`timescale 1ns/1ps
module keypad_scanner_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] row_in;
    logic       scan_tick = 1'b0;
    logic [3:0] col_drive, key_col;
    logic [7:0] key_row;
    logic       key_valid, key_held;

    int checks = 0, failures = 0, cycles = 0;
    logic [7:0] mat [4] = '{default: 8'h00};
    bit  auto_en = 1'b1, manual_req = 1'b0;
    int  div = 4, tcnt = 0;

    // Reference model state
    int   m_col = 1, m_kcol = 0, m_krow = 0, m_pv = 0;
    bit   m_held = 0, m_valid = 0, m_pend = 0;
    int   m_hist[$] = '{0, 0};

    always #10 clk = ~clk;

    keypad_scanner uut (
        .clk(clk), .rst_n(rst_n), .row_in(row_in), .scan_tick(scan_tick),
        .col_drive(col_drive), .key_valid(key_valid), .key_col(key_col),
        .key_row(key_row), .key_held(key_held)
    );

    always_comb begin
        row_in = 8'h00;
        for (int i = 0; i < 4; i++) if (col_drive[i]) row_in = row_in | mat[i];
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int next_col(input int c);
        return (c == 8) ? 1 : c * 2;
    endfunction

    always @(negedge clk) begin
        if (manual_req) begin
            scan_tick <= 1'b1; manual_req = 1'b0;
        end else if (auto_en) begin
            scan_tick <= (tcnt >= div - 1);
            tcnt = (tcnt >= div - 1) ? 0 : tcnt + 1;
        end else begin
            scan_tick <= 1'b0;
        end
    end

    always @(posedge clk) begin
        int s;
        if (!rst_n) begin
            m_col = 1; m_kcol = 0; m_krow = 0; m_pv = 0;
            m_held = 0; m_valid = 0; m_pend = 0; m_hist = '{0, 0};
        end else begin
            s = m_hist[1];
            m_valid = 0;
            if (scan_tick) begin
                if (!m_held) begin
                    if (s != 0) begin
                        m_held = 1; m_valid = 1; m_kcol = m_col; m_krow = s; m_pend = 0;
                    end else m_col = next_col(m_col);
                end else if (s == m_krow) m_pend = 0;
                else if (m_pend && s == m_pv) begin
                    m_held = 0; m_pend = 0; m_col = next_col(m_col);
                end else begin
                    m_pend = 1; m_pv = s;
                end
            end
            m_hist.push_front(int'(row_in));
            void'(m_hist.pop_back());
        end
    end

    // Cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", "col_drive", 32'(col_drive), 32'(m_col));
            chk("R6", "key_valid", 32'(key_valid), 32'(m_valid));
            chk("R7", "key_held",  32'(key_held),  32'(m_held));
            chk("R3", "key_col",   32'(key_col),   32'(m_kcol));
            chk("R3", "key_row",   32'(key_row),   32'(m_krow));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!scan_tick) @(posedge clk);
        end
    endtask

    task automatic wait_valid(output bit seen);
        seen = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (key_valid) seen = 1;
        end
    endtask

    function automatic int col_idx(input logic [3:0] c);
        for (int i = 0; i < 4; i++) if (c[i]) return i;
        return 0;
    endfunction

    initial begin
        bit seen;
        int pulses;
        logic [3:0] c0;
        repeat (3) @(negedge clk);
        chk("R10", "reset col",   32'(col_drive), 32'h1);
        chk("R10", "reset valid", 32'(key_valid), 32'h0);
        chk("R10", "reset held",  32'(key_held),  32'h0);
        chk("R10", "reset row",   32'(key_row),   32'h0);
        @(posedge clk); rst_n = 1'b1;

        // R1 R4: idle scan steps through every column and wraps
        wait_ticks(1); @(negedge clk);
        chk("R4", "advance on empty tick", 32'(col_drive), 32'h2);
        wait_ticks(3); @(negedge clk);
        chk("R1", "wrap to first column", 32'(col_drive), 32'h1);

        // R3 R5 R6 R7: single key in the second column
        mat[1] = 8'h10;
        wait_valid(seen);
        chk("R3", "report seen", 32'(seen), 32'h1);
        chk("R3", "reported col", 32'(key_col), 32'h2);
        chk("R3", "reported row", 32'(key_row), 32'h10);
        chk("R7", "held with pulse", 32'(key_held), 32'h1);
        pulses = 0;
        repeat (40) begin @(negedge clk); if (key_valid) pulses++; end
        chk("R6", "no repeat pulse", 32'(pulses), 32'h0);
        chk("R5", "column parked", 32'(col_drive), 32'h2);

        // R8: one-tick bounce does not release
        wait_ticks(1); mat[1] = 8'h30;
        wait_ticks(1); mat[1] = 8'h10;
        wait_ticks(2); @(negedge clk);
        chk("R8", "bounce ignored", 32'(key_held), 32'h1);
        chk("R8", "bounce column", 32'(col_drive), 32'h2);

        // R8: two-tick miss of a third value (0x30 then 0x70) does not release
        wait_ticks(1); mat[1] = 8'h30;
        wait_ticks(1); mat[1] = 8'h70;
        wait_ticks(1); mat[1] = 8'h10;
        wait_ticks(2); @(negedge clk);
        chk("R8", "alternating change ignored", 32'(key_held), 32'h1);

        // R5 R8: true release advances
        wait_ticks(1); mat[1] = 8'h00;
        wait_ticks(2); @(negedge clk);
        chk("R8", "released after two ticks", 32'(key_held), 32'h0);
        chk("R5", "advance on release", 32'(col_drive), 32'h4);

        // R3: two switches in the last column, raw byte reported
        mat[3] = 8'h81;
        wait_valid(seen);
        chk("R3", "multi col", 32'(key_col), 32'h8);
        chk("R3", "multi raw row", 32'(key_row), 32'h81);
        // release onto another nonzero byte, then rescan after wrap
        wait_ticks(1); mat[3] = 8'h01;
        wait_ticks(2); @(negedge clk);
        chk("R8", "release to new byte", 32'(key_held), 32'h0);
        chk("R1", "wrap after release", 32'(col_drive), 32'h1);
        wait_valid(seen);
        chk("R3", "rescan reports new byte", 32'(key_row), 32'h01);
        wait_ticks(1); mat[3] = 8'h00;
        wait_ticks(3);

        // R2: no tick, no movement
        @(posedge clk); auto_en = 0;
        repeat (3) @(negedge clk);
        c0 = col_drive;
        repeat (20) @(negedge clk);
        chk("R2", "column stable without tick", 32'(col_drive), 32'(c0));

        // R9: tick on the first edge after a row change sees the old value
        @(posedge clk); mat[col_idx(col_drive)] = 8'h04; manual_req = 1;
        @(posedge clk); @(negedge clk);
        chk("R9", "stale row no report", 32'(key_valid), 32'h0);
        chk("R9", "stale row advances", 32'(col_drive), 32'(c0 == 4'h8 ? 4'h1 : c0 << 1));
        @(posedge clk); mat[col_idx(c0)] = 8'h00;

        // R9: tick every cycle; model tracks the synchroniser skew
        @(posedge clk); div = 1; tcnt = 0; auto_en = 1;
        mat[2] = 8'h02;
        wait_valid(seen);
        chk("R9", "fast scan report", 32'(key_row), 32'h02);
        mat[2] = 8'h00;
        for (int i = 0; i < 200 && key_held; i++) @(negedge clk);
        chk("R7", "held drops after release", 32'(key_held), 32'h0);
        repeat (20) @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule